// File: doc/BRIEF.md
# Time-Slot Signaling Byte Inserter

This block sits in the transmit path of a 32-slot framed stream. For each slot it sees one strobe, the slot number, and the frame byte that would go out in that slot. A 32-bit select mask marks the slots that carry signaling data. In those slots the block puts bytes taken from a show-ahead transmit FIFO. When there is nothing to send, it puts an idle pattern there instead. Slots that are not selected pass the frame byte through unchanged. Every slot appears at the output one clock after its strobe.

Transmission can start freely, in the next selected slot after data appears. It can also be held back until a multiframe boundary, so that the first queued byte lands in the first selected slot of a multiframe. Once started, a transmission takes one byte per selected slot until the FIFO is empty. The mask and the alignment setting are copied into working registers only at the multiframe boundary. A frame therefore never runs under mixed settings. The idle pattern and the master enable take effect at once.

Top module: `ts_sig_inserter`

## Requirements
- R1: While `cfg_enable` is 0, every slot carries its frame byte and `fifo_rd` stays 0.
- R2: A slot whose working-mask bit is 0 outputs `frm_data` one cycle after its strobe, with `out_valid` high in that cycle.
- R3: A selected slot that has no data to send carries 0xFF when `cfg_flag_idle` is 0 and 0x7E when it is 1.
- R4: With the working alignment bit at 0, queued bytes start in the next selected slot and fill the selected slots one byte each, in ascending slot order, across frames.
- R5: With the working alignment bit at 1, a start happens only in the first selected slot at or after a strobe with `mf_sync` high. Queued data waits through the other frames, and the FIFO is not read.
- R6: A started transmission continues until the FIFO is empty. After that, the selected slots carry idle fill, and a new aligned start waits for the next multiframe boundary.
- R7: `cfg_mask` and `cfg_align` are copied into the working registers only on a slot strobe with `mf_sync` high, and they apply from that slot onward.
- R8: In aligned mode, a selected slot that finds the FIFO empty during an active transmission carries idle fill with `underrun` high. In free-start mode, `underrun` stays 0.
- R9: After reset the working mask is 0, so every slot passes through and nothing is read until the first multiframe boundary.
- R10: `fifo_rd` is high only in a cycle when `fifo_empty` is 0 and a selected slot is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Master enable for insertion |
| cfg_flag_idle | input | 1 | Idle pattern: 0 gives 0xFF, 1 gives 0x7E |
| cfg_align | input | 1 | Start transmissions only at a multiframe boundary |
| cfg_mask | input | 32 | Slot select mask, bit n for slot n |
| slot_vld | input | 1 | One strobe per slot |
| slot_idx | input | 5 | Number of the strobed slot |
| mf_sync | input | 1 | Marks the strobe of slot 0 of a multiframe |
| frm_data | input | 8 | Frame byte for the strobed slot |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the head byte |
| out_valid | output | 1 | Output byte valid, one cycle after `slot_vld` |
| out_data | output | 8 | Byte sent in the slot |
| underrun | output | 1 | Aligned transmission ran dry in this slot |

## Verification
The bench writes new settings partway through a multiframe and checks that the old mask and the old alignment still govern that frame. A design that applied the settings at once would move bytes into the wrong slots. It pushes data between boundaries while aligned mode is on. A design that started too early would read the FIFO and shift every byte by a frame. It lets an aligned transmission run dry across a frame edge to catch a missing or spurious `underrun`. It also checks that an ended aligned transmission does not restart before the next boundary. Runs in free-start mode across frames check byte order and confirm that `underrun` stays low there.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_ONES = 8'hFF;
    localparam logic [BYTE_W-1:0] IDLE_FLAG = 8'h7E;

    // Per-slot decision handed from the sequencer to the output stage
    typedef struct packed {
        logic sel;   // slot is selected for signaling
        logic send;  // FIFO head byte goes into this slot
        logic ur;    // aligned transmission ran dry here
    } slot_act_t;

    function automatic logic [BYTE_W-1:0] idle_byte(input logic flag_mode);
        return flag_mode ? IDLE_FLAG : IDLE_ONES;
    endfunction

endpackage

// File: rtl/ts_cfg_shadow.sv
module ts_cfg_shadow #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_vld,
    input  logic                 mf_sync,
    input  logic [NUM_SLOTS-1:0] cfg_mask,
    input  logic                 cfg_align,
    output logic [NUM_SLOTS-1:0] eff_mask,
    output logic                 eff_align
);
    logic [NUM_SLOTS-1:0] mask_q;
    logic                 align_q;
    logic                 load;

    assign load = slot_vld && mf_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            align_q <= 1'b0;
        end else if (load) begin
            mask_q  <= cfg_mask;
            align_q <= cfg_align;
        end
    end

    // the boundary slot itself already runs under the new settings
    assign eff_mask  = load ? cfg_mask  : mask_q;
    assign eff_align = load ? cfg_align : align_q;

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(slot_vld && mf_sync) |=> ($stable(mask_q) && $stable(align_q)));

endmodule

// File: rtl/ts_slot_seq.sv
module ts_slot_seq
    import ts_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_vld,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 mf_sync,
    input  logic                 cfg_enable,
    input  logic [NUM_SLOTS-1:0] eff_mask,
    input  logic                 eff_align,
    input  logic                 fifo_empty,
    output slot_act_t            act,
    output logic                 fifo_rd
);
    logic [NUM_SLOTS-1:0] hit;
    logic                 tx_act;
    logic                 first_q;
    logic                 first_now;
    logic                 sel;
    logic                 send;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
        assign hit[g] = eff_mask[g] && (slot_idx == SLOT_W'(g));
    end

    assign sel       = slot_vld && cfg_enable && (|hit);
    assign first_now = (slot_vld && mf_sync) || first_q;
    assign send      = sel && !fifo_empty && (tx_act || !eff_align || first_now);

    always_comb begin
        act.sel  = sel;
        act.send = send;
        act.ur   = sel && tx_act && fifo_empty && eff_align;
    end

    assign fifo_rd = send;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_act  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            if (sel) begin
                tx_act <= send;
            end
            if (slot_vld && mf_sync) begin
                first_q <= !sel;
            end else if (sel) begin
                first_q <= 1'b0;
            end
        end
    end

    p_rd_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    p_rd_enabled_r1: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (cfg_enable && slot_vld));

    p_ur_no_send_r8: assert property (@(posedge clk) disable iff (rst)
        act.ur |-> !fifo_rd);

endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage
    import ts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_vld,
    input  slot_act_t         act,
    input  logic              cfg_flag_idle,
    input  logic [BYTE_W-1:0] frm_data,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              underrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            underrun  <= 1'b0;
        end else begin
            out_valid <= slot_vld;
            underrun  <= act.ur;
            if (act.send) begin
                out_data <= fifo_data;
            end else if (act.sel) begin
                out_data <= idle_byte(cfg_flag_idle);
            end else begin
                out_data <= frm_data;
            end
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        slot_vld |=> out_valid);

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && !act.sel) |=> (out_data == $past(frm_data)));

    p_ur_idle_r8: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (out_valid && out_data == idle_byte($past(cfg_flag_idle))));

endmodule

// File: rtl/ts_sig_inserter.sv
module ts_sig_inserter
    import ts_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_enable,
    input  logic                 cfg_flag_idle,
    input  logic                 cfg_align,
    input  logic [NUM_SLOTS-1:0] cfg_mask,
    input  logic                 slot_vld,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 mf_sync,
    input  logic [BYTE_W-1:0]    frm_data,
    input  logic                 fifo_empty,
    input  logic [BYTE_W-1:0]    fifo_data,
    output logic                 fifo_rd,
    output logic                 out_valid,
    output logic [BYTE_W-1:0]    out_data,
    output logic                 underrun
);
    logic [NUM_SLOTS-1:0] eff_mask;
    logic                 eff_align;
    slot_act_t            act;

    ts_cfg_shadow #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .slot_vld  (slot_vld),
        .mf_sync   (mf_sync),
        .cfg_mask  (cfg_mask),
        .cfg_align (cfg_align),
        .eff_mask  (eff_mask),
        .eff_align (eff_align)
    );

    ts_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .slot_vld   (slot_vld),
        .slot_idx   (slot_idx),
        .mf_sync    (mf_sync),
        .cfg_enable (cfg_enable),
        .eff_mask   (eff_mask),
        .eff_align  (eff_align),
        .fifo_empty (fifo_empty),
        .act        (act),
        .fifo_rd    (fifo_rd)
    );

    ts_out_stage u_out (
        .clk           (clk),
        .rst           (rst),
        .slot_vld      (slot_vld),
        .act           (act),
        .cfg_flag_idle (cfg_flag_idle),
        .frm_data      (frm_data),
        .fifo_data     (fifo_data),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .underrun      (underrun)
    );

    p_rd_selected_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (slot_vld && cfg_mask[slot_idx] || slot_vld && eff_mask[slot_idx]));

endmodule

// File: tb/ts_sig_inserter_bench.sv
`timescale 1ns/1ps
module ts_sig_inserter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_flag_idle = 1'b0;
    logic        cfg_align = 1'b0;
    logic [31:0] cfg_mask = '0;
    logic        slot_vld = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic        mf_sync = 1'b0;
    logic [7:0]  frm_data = '0;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        fifo_rd;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        underrun;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] fmem [0:15];
    int wr_ptr = 0;
    int rd_ptr = 0;

    logic [7:0]  exp_d [0:31];
    logic [31:0] exp_u;

    always #2 clk = ~clk;

    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_data  = fmem[rd_ptr % 16];

    always @(posedge clk) begin
        if (fifo_rd && !fifo_empty) rd_ptr <= rd_ptr + 1;
    end

    ts_sig_inserter u_ts_sig_inserter (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_flag_idle(cfg_flag_idle),
        .cfg_align(cfg_align), .cfg_mask(cfg_mask), .slot_vld(slot_vld),
        .slot_idx(slot_idx), .mf_sync(mf_sync), .frm_data(frm_data),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .out_valid(out_valid), .out_data(out_data), .underrun(underrun)
    );

    task automatic push(input logic [7:0] b);
        fmem[wr_ptr % 16] = b;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic expect_pass();
        for (int i = 0; i < 32; i++) exp_d[i] = 8'h40 + 8'(i);
        exp_u = '0;
    endtask

    task automatic check_level(input int lvl, input string tag);
        total++;
        if (wr_ptr - rd_ptr != lvl) begin
            bad++;
            $display("FAIL %s fifo level actual=%0d expected=%0d", tag, wr_ptr - rd_ptr, lvl);
        end
    endtask

    // drives 32 slots back to back, compares each against exp_d/exp_u
    task automatic run_frame(input bit mf, input string tag);
        bit ok = 1;
        for (int i = 0; i < 32; i++) begin
            slot_vld = 1'b1;
            slot_idx = 5'(i);
            mf_sync  = mf && (i == 0);
            frm_data = 8'h40 + 8'(i);
            @(negedge clk);
            if (ok && (out_valid !== 1'b1 || out_data !== exp_d[i] || underrun !== exp_u[i])) begin
                ok = 0;
                $display("FAIL %s slot %0d actual=%h/v%0b/u%0b expected=%h/v1/u%0b",
                         tag, i, out_data, out_valid, underrun, exp_d[i], exp_u[i]);
            end
        end
        slot_vld = 1'b0;
        mf_sync  = 1'b0;
        @(negedge clk);
        total++;
        if (!ok) bad++;
    endtask

    task automatic t_reset();
        total++;
        if (out_valid !== 1'b0 || underrun !== 1'b0 || fifo_rd !== 1'b0) begin
            bad++;
            $display("FAIL R9 reset outputs actual=v%0b u%0b r%0b expected=0 0 0", out_valid, underrun, fifo_rd);
        end
        push(8'hC1); push(8'hC2);
        cfg_enable = 1; cfg_mask = '1; cfg_align = 0;
        expect_pass();
        run_frame(0, "R9 mask clear after reset");
        check_level(2, "R9");
    endtask

    task automatic t_disabled();
        cfg_enable = 0;
        expect_pass();
        run_frame(1, "R1 disabled pass-through");
        check_level(2, "R1");
    endtask

    task automatic t_idle();
        cfg_enable = 1;
        expect_pass();
        for (int i = 0; i < 32; i++) exp_d[i] = 8'hFF;
        exp_d[0] = 8'hC1; exp_d[1] = 8'hC2;
        run_frame(0, "R4 free start then R3 ones fill");
        check_level(0, "R4");
        cfg_mask = (32'h1 << 3) | (32'h1 << 7);
        expect_pass(); exp_d[3] = 8'hFF; exp_d[7] = 8'hFF;
        run_frame(1, "R2 R3 ones fill in masked slots");
        cfg_flag_idle = 1;
        expect_pass(); exp_d[3] = 8'h7E; exp_d[7] = 8'h7E;
        run_frame(0, "R3 flag fill");
    endtask

    task automatic t_free();
        cfg_mask = (32'h1 << 2) | (32'h1 << 5) | (32'h1 << 30);
        expect_pass(); exp_d[2] = 8'h7E; exp_d[5] = 8'h7E; exp_d[30] = 8'h7E;
        run_frame(1, "R7 new mask at boundary");
        cfg_flag_idle = 0;
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
        expect_pass(); exp_d[2] = 8'hA1; exp_d[5] = 8'hA2; exp_d[30] = 8'hA3;
        run_frame(0, "R4 ascending order");
        expect_pass(); exp_d[2] = 8'hA4; exp_d[5] = 8'hFF; exp_d[30] = 8'hFF;
        run_frame(0, "R6 R8 free run drains, no underrun");
        check_level(0, "R6");
    endtask

    task automatic t_aligned();
        cfg_align = 1;
        cfg_mask = (32'h1 << 1) | (32'h1 << 4);
        expect_pass(); exp_d[1] = 8'hFF; exp_d[4] = 8'hFF;
        run_frame(1, "R7 aligned settings latched");
        push(8'hB1); push(8'hB2); push(8'hB3);
        run_frame(0, "R5 waits for boundary");
        check_level(3, "R5");
        exp_d[1] = 8'hB1; exp_d[4] = 8'hB2;
        run_frame(1, "R5 aligned start");
        exp_d[1] = 8'hB3; exp_d[4] = 8'hFF; exp_u[4] = 1'b1;
        run_frame(0, "R8 underrun");
        push(8'hB4); push(8'hB5);
        expect_pass(); exp_d[1] = 8'hFF; exp_d[4] = 8'hFF;
        run_frame(0, "R6 no restart before boundary");
        check_level(2, "R6");
        exp_d[1] = 8'hB4; exp_d[4] = 8'hB5;
        run_frame(1, "R5 second aligned start");
        exp_d[1] = 8'hFF; exp_d[4] = 8'hFF; exp_u[1] = 1'b1;
        run_frame(0, "R8 underrun ends run");
    endtask

    task automatic t_shadow();
        cfg_mask = 32'h1 << 10;
        cfg_align = 0;
        expect_pass(); exp_d[1] = 8'hFF; exp_d[4] = 8'hFF;
        run_frame(0, "R7 old mask kept mid-multiframe");
        push(8'hD1);
        run_frame(0, "R7 old alignment kept");
        check_level(1, "R7");
        expect_pass(); exp_d[10] = 8'hD1;
        run_frame(1, "R7 new mask and free start at boundary");
        check_level(0, "R7");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_idle();
        t_free();
        t_aligned();
        t_shadow();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule